// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the register-side front end of a 16550-style serial port. A host reaches it through a single-cycle 16-bit access port. Each register sits in its own 32-bit-aligned slot and holds 8 meaningful bits; the upper bits of the data bus read as zero. The block stores the baud divisor, line format, modem control, interrupt enables, a global control byte and a scratch byte, and drives these settings out to the serial core. The core reports receive, transmit and clear-to-send events on single-cycle strobes. The block turns those strobes into line-status and modem-status bits, which are sticky or clear on read. It combines the enabled sources into one interrupt request.

The two lowest slots are overloaded. Bit 7 of the line-format register (the divisor access bit) decides what they reach. When the bit is set, slot 0x00 holds the divisor low byte and slot 0x04 holds the divisor high byte. When the bit is clear, slot 0x00 is the transmit data port on write and the receive data port on read, and slot 0x04 holds the interrupt enables. Read data is combinational from the address. The clear-on-read effects take place at the clock edge that ends the read.

Top module: `uart_csr_file`

## Requirements
- R1: After reset, every stored register reads 0, the line-status slot (0x14) reads 0x0060, the divisor output is 0, and irq and tx_load are 0.
- R2: With line-format bit 7 set, slot 0x00 reads and writes the divisor low byte and slot 0x04 the divisor high byte. The divisor output is {high, low}. In this state no transmit load occurs and the interrupt enables do not change.
- R3: With line-format bit 7 clear, a write to slot 0x00 pulses tx_load for exactly the following cycle with tx_byte equal to the written byte. The same write clears line-status bits 5 (holding empty), 6 (transmitter empty) and 7 (finished). A write to slot 0x04 sets the 4 interrupt-enable bits, and the upper bits of that slot read as 0.
- R4: Line-format register at 0x0C: bits[1:0] drive word_len_m5, bit2 stop_ext, bit3 parity_en, bit4 parity_even, bit5 parity_stick, bit6 break_force.
- R5: rx_push stores rx_byte and sets line-status bit 0 (data ready). A read of slot 0x00 with bit 7 clear returns the byte and clears bit 0, unless a new push arrives in the same cycle.
- R6: rx_push while bit 0 is already set sets line-status bit 1 (overrun), and the newest byte replaces the stored one.
- R7: rx_par_err, rx_frm_err and rx_brk set line-status bits 2, 3 and 4. These bits stay set until a line-status read, which returns them and then clears them together with bit 1. A new event in the same cycle as the read wins. A line-status read does not touch bit 0.
- R8: tx_pop sets bit 5 and clears bit 6. tx_shift_done while bit 5 is set sets bits 6 and 7. tx_shift_done while bit 5 is clear has no effect.
- R9: Modem-status slot 0x18: bit 4 follows cts_level, and bit 0 is set by cts_change and cleared by a read of the slot.
- R10: One cycle after its cause, irq equals the OR of: enable bit 0 with data ready, enable bit 1 with holding empty, enable bit 2 with any of line-status bits 1 to 4, and enable bit 3 with modem-status bit 0.
- R11: Modem control (0x10), scratch (0x1C) and global control (0x24) read back as written. Modem bit 4 drives loop_en. Global bit 0 drives uart_clk_en, bit 4 drives tx_force_par_err and bit 5 drives tx_force_frm_err. modem_ctl carries the whole modem byte.
- R12: Writes to slots 0x08, 0x14 and 0x18, to unmapped slots, and to addresses whose two low bits are not zero change nothing. Reads of these addresses (except 0x14 and 0x18) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data; bits 7:0 used |
| bus_rdata | output | DATA_W | Combinational read data |
| rx_push | input | 1 | Core delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error event |
| rx_frm_err | input | 1 | Framing error event |
| rx_brk | input | 1 | Break detected event |
| tx_pop | input | 1 | Core takes the holding byte into its shifter |
| tx_shift_done | input | 1 | Core finished shifting out the last bit |
| tx_load | output | 1 | One-cycle pulse, a new transmit byte is held |
| tx_byte | output | 8 | Held transmit byte |
| cts_level | input | 1 | Present clear-to-send level |
| cts_change | input | 1 | Clear-to-send changed event |
| divisor | output | 16 | Baud divisor {high, low} |
| word_len_m5 | output | 2 | Character length minus five |
| stop_ext | output | 1 | Extra stop bit select |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity select |
| break_force | output | 1 | Force break on the line |
| modem_ctl | output | 8 | Modem control byte |
| loop_en | output | 1 | Loopback enable |
| uart_clk_en | output | 1 | Serial core clock enable |
| tx_force_par_err | output | 1 | Corrupt parity on transmit |
| tx_force_frm_err | output | 1 | Corrupt stop bit on transmit |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or mis-cleared status flag shows in the line-status readback on the very next access, and in irq one cycle after its cause. This is why the bench reads status twice around each event: once to see the flag set and once to see it cleared. A decode fault that lets the divisor access bit leak shows at once as a wrong readback on slots 0x00 and 0x04, as a stray tx_load pulse, or as a moved divisor output. A wrong priority between an event and its clearing read would lose a flag that the next read should still return.

// File: rtl/uart_csr_pkg.sv
`timescale 1ns/1ps
package uart_csr_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned IER_W    = 4;
   localparam int unsigned SLOT_LSB = 2;

   // slot indices (byte offset / 4)
   localparam int unsigned IDX_DATA  = 0;
   localparam int unsigned IDX_IEN   = 1;
   localparam int unsigned IDX_LFMT  = 3;
   localparam int unsigned IDX_MCTL  = 4;
   localparam int unsigned IDX_LSTAT = 5;
   localparam int unsigned IDX_MSTAT = 6;
   localparam int unsigned IDX_SCR   = 7;
   localparam int unsigned IDX_GCTL  = 9;

   typedef enum logic [3:0] {
      TGT_NONE, TGT_RXTX, TGT_DIVLO, TGT_DIVHI, TGT_IEN, TGT_LFMT,
      TGT_MCTL, TGT_LSTAT, TGT_MSTAT, TGT_SCR, TGT_GCTL
   } tgt_e;

   typedef struct packed {
      logic       div_acc;
      logic       brk;
      logic       stick;
      logic       even;
      logic       par;
      logic       stop2;
      logic [1:0] wlen;
   } lfmt_t;
endpackage

// File: rtl/uart_csr_decode.sv
`timescale 1ns/1ps
module uart_csr_decode
   import uart_csr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              div_acc,
   output tgt_e              tgt,
   output logic              wr_thr,
   output logic              wr_dll,
   output logic              wr_dlh,
   output logic              wr_ien,
   output logic              wr_lfmt,
   output logic              wr_mctl,
   output logic              wr_scr,
   output logic              wr_gctl,
   output logic              rd_rbr,
   output logic              rd_lstat,
   output logic              rd_mstat
);
   localparam int unsigned IDX_W = ADDR_W - SLOT_LSB;

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic             wr;
   logic             rd;

   assign idx     = bus_addr[ADDR_W-1:SLOT_LSB];
   assign aligned = (bus_addr[SLOT_LSB-1:0] == '0);
   assign wr      = bus_en & bus_we;
   assign rd      = bus_en & ~bus_we;

   always_comb begin
      tgt = TGT_NONE;
      if (aligned) begin
         if (idx == IDX_W'(IDX_DATA))       tgt = div_acc ? TGT_DIVLO : TGT_RXTX;
         else if (idx == IDX_W'(IDX_IEN))   tgt = div_acc ? TGT_DIVHI : TGT_IEN;
         else if (idx == IDX_W'(IDX_LFMT))  tgt = TGT_LFMT;
         else if (idx == IDX_W'(IDX_MCTL))  tgt = TGT_MCTL;
         else if (idx == IDX_W'(IDX_LSTAT)) tgt = TGT_LSTAT;
         else if (idx == IDX_W'(IDX_MSTAT)) tgt = TGT_MSTAT;
         else if (idx == IDX_W'(IDX_SCR))   tgt = TGT_SCR;
         else if (idx == IDX_W'(IDX_GCTL))  tgt = TGT_GCTL;
      end
   end

   assign wr_thr   = wr && (tgt == TGT_RXTX);
   assign wr_dll   = wr && (tgt == TGT_DIVLO);
   assign wr_dlh   = wr && (tgt == TGT_DIVHI);
   assign wr_ien   = wr && (tgt == TGT_IEN);
   assign wr_lfmt  = wr && (tgt == TGT_LFMT);
   assign wr_mctl  = wr && (tgt == TGT_MCTL);
   assign wr_scr   = wr && (tgt == TGT_SCR);
   assign wr_gctl  = wr && (tgt == TGT_GCTL);
   assign rd_rbr   = rd && (tgt == TGT_RXTX);
   assign rd_lstat = rd && (tgt == TGT_LSTAT);
   assign rd_mstat = rd && (tgt == TGT_MSTAT);
endmodule

// File: rtl/uart_csr_status.sv
`timescale 1ns/1ps
module uart_csr_status
   import uart_csr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_push,
   input  logic             rx_par_err,
   input  logic             rx_frm_err,
   input  logic             rx_brk,
   input  logic             tx_pop,
   input  logic             tx_shift_done,
   input  logic             cts_level,
   input  logic             cts_change,
   input  logic             wr_thr,
   input  logic             rd_rbr,
   input  logic             rd_lstat,
   input  logic             rd_mstat,
   output logic [REG_W-1:0] lstat,
   output logic [REG_W-1:0] mstat
);
   logic dr_q, oe_q, pe_q, fe_q, bi_q, thre_q, temt_q, fin_q, dcts_q;
   logic drain_ok;

   // the last bit left the shifter with nothing waiting behind it
   assign drain_ok = tx_shift_done & thre_q & ~tx_pop & ~wr_thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q   <= 1'b0;
         oe_q   <= 1'b0;
         pe_q   <= 1'b0;
         fe_q   <= 1'b0;
         bi_q   <= 1'b0;
         thre_q <= 1'b1;
         temt_q <= 1'b1;
         fin_q  <= 1'b0;
         dcts_q <= 1'b0;
      end else begin
         // receive side: events win over the clearing read
         if (rx_push)       dr_q <= 1'b1;
         else if (rd_rbr)   dr_q <= 1'b0;

         if (rx_push && dr_q) oe_q <= 1'b1;
         else if (rd_lstat)   oe_q <= 1'b0;

         if (rx_par_err)    pe_q <= 1'b1;
         else if (rd_lstat) pe_q <= 1'b0;

         if (rx_frm_err)    fe_q <= 1'b1;
         else if (rd_lstat) fe_q <= 1'b0;

         if (rx_brk)        bi_q <= 1'b1;
         else if (rd_lstat) bi_q <= 1'b0;

         // transmit side: a new host byte wins over the core's pop
         if (wr_thr)      thre_q <= 1'b0;
         else if (tx_pop) thre_q <= 1'b1;

         if (wr_thr || tx_pop) temt_q <= 1'b0;
         else if (drain_ok)    temt_q <= 1'b1;

         if (wr_thr)        fin_q <= 1'b0;
         else if (drain_ok) fin_q <= 1'b1;

         if (cts_change)    dcts_q <= 1'b1;
         else if (rd_mstat) dcts_q <= 1'b0;
      end
   end

   assign lstat = {fin_q, temt_q, thre_q, bi_q, fe_q, pe_q, oe_q, dr_q};
   assign mstat = {3'b000, cts_level, 3'b000, dcts_q};

   AST_RBR_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rbr && !rx_push |=> !lstat[0]); // R5
   AST_DOUBLE_PUSH_OVERRUNS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && lstat[0] |=> lstat[1]); // R6
   AST_LSTAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lstat && !rx_push && !rx_par_err && !rx_frm_err && !rx_brk |=> lstat[4:1] == 4'b0000); // R7
   AST_EMPTY_NEEDS_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      lstat[6] |-> lstat[5]); // R8
   AST_MSTAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mstat && !cts_change |=> !mstat[0]); // R9
endmodule

// File: rtl/uart_csr_irq.sv
`timescale 1ns/1ps
module uart_csr_irq
   import uart_csr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IER_W-1:0] ien,
   input  logic             rx_ready,
   input  logic             tx_hold_empty,
   input  logic             line_err,
   input  logic             modem_delta,
   output logic             irq
);
   logic req_c;

   assign req_c = (ien[0] & rx_ready) | (ien[1] & tx_hold_empty)
                | (ien[2] & line_err) | (ien[3] & modem_delta);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= req_c;
      end
      assign irq = irq_q;

      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         (ien == '0) |=> !irq); // R10
      AST_IRQ_RX_READY: assert property (@(posedge clk) disable iff (!rst_n)
         ien[0] && rx_ready |=> irq); // R10
   end else begin : g_comb
      assign irq = req_c;

      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         (ien == '0) |-> !irq); // R10
   end
endmodule

// File: rtl/uart_csr_file.sv
`timescale 1ns/1ps
module uart_csr_file
   import uart_csr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              rx_brk,
   input  logic              tx_pop,
   input  logic              tx_shift_done,
   output logic              tx_load,
   output logic [7:0]        tx_byte,
   input  logic              cts_level,
   input  logic              cts_change,
   output logic [15:0]       divisor,
   output logic [1:0]        word_len_m5,
   output logic              stop_ext,
   output logic              parity_en,
   output logic              parity_even,
   output logic              parity_stick,
   output logic              break_force,
   output logic [7:0]        modem_ctl,
   output logic              loop_en,
   output logic              uart_clk_en,
   output logic              tx_force_par_err,
   output logic              tx_force_frm_err,
   output logic              irq
);
   localparam int unsigned MIN_ADDR_W = SLOT_LSB + 4;

   if (ADDR_W < MIN_ADDR_W) begin : g_chk_addr
      $error("uart_csr_file: ADDR_W too small for slot 0x24");
   end
   if (DATA_W < REG_W) begin : g_chk_data
      $error("uart_csr_file: DATA_W narrower than a register");
   end

   tgt_e             tgt;
   logic             wr_thr, wr_dll, wr_dlh, wr_ien, wr_lfmt, wr_mctl, wr_scr, wr_gctl;
   logic             rd_rbr, rd_lstat, rd_mstat;
   logic [REG_W-1:0] dll_q, dlh_q, mctl_q, scr_q, gctl_q, rbr_q, thr_q;
   logic [IER_W-1:0] ien_q;
   lfmt_t            lfmt_q;
   logic             load_q;
   logic [REG_W-1:0] lstat, mstat;
   logic [REG_W-1:0] rd_byte;
   logic [REG_W-1:0] wbyte;
   logic             unused_wdata;

   assign wbyte        = bus_wdata[REG_W-1:0];
   assign unused_wdata = ^bus_wdata;

   uart_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
      .bus_en   (bus_en),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .div_acc  (lfmt_q.div_acc),
      .tgt      (tgt),
      .wr_thr   (wr_thr),
      .wr_dll   (wr_dll),
      .wr_dlh   (wr_dlh),
      .wr_ien   (wr_ien),
      .wr_lfmt  (wr_lfmt),
      .wr_mctl  (wr_mctl),
      .wr_scr   (wr_scr),
      .wr_gctl  (wr_gctl),
      .rd_rbr   (rd_rbr),
      .rd_lstat (rd_lstat),
      .rd_mstat (rd_mstat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_q  <= '0;
         dlh_q  <= '0;
         ien_q  <= '0;
         lfmt_q <= '0;
         mctl_q <= '0;
         scr_q  <= '0;
         gctl_q <= '0;
         rbr_q  <= '0;
         thr_q  <= '0;
         load_q <= 1'b0;
      end else begin
         if (wr_dll)  dll_q  <= wbyte;
         if (wr_dlh)  dlh_q  <= wbyte;
         if (wr_ien)  ien_q  <= wbyte[IER_W-1:0];
         if (wr_lfmt) lfmt_q <= lfmt_t'(wbyte);
         if (wr_mctl) mctl_q <= wbyte;
         if (wr_scr)  scr_q  <= wbyte;
         if (wr_gctl) gctl_q <= wbyte;
         if (rx_push) rbr_q  <= rx_byte;
         if (wr_thr)  thr_q  <= wbyte;
         load_q <= wr_thr;
      end
   end

   uart_csr_status i_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_push       (rx_push),
      .rx_par_err    (rx_par_err),
      .rx_frm_err    (rx_frm_err),
      .rx_brk        (rx_brk),
      .tx_pop        (tx_pop),
      .tx_shift_done (tx_shift_done),
      .cts_level     (cts_level),
      .cts_change    (cts_change),
      .wr_thr        (wr_thr),
      .rd_rbr        (rd_rbr),
      .rd_lstat      (rd_lstat),
      .rd_mstat      (rd_mstat),
      .lstat         (lstat),
      .mstat         (mstat)
   );

   uart_csr_irq #(.IRQ_REG(IRQ_REG)) i_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .ien           (ien_q),
      .rx_ready      (lstat[0]),
      .tx_hold_empty (lstat[5]),
      .line_err      (|lstat[4:1]),
      .modem_delta   (mstat[0]),
      .irq           (irq)
   );

   always_comb begin
      unique case (tgt)
         TGT_RXTX:  rd_byte = rbr_q;
         TGT_DIVLO: rd_byte = dll_q;
         TGT_DIVHI: rd_byte = dlh_q;
         TGT_IEN:   rd_byte = REG_W'(ien_q);
         TGT_LFMT:  rd_byte = REG_W'(lfmt_q);
         TGT_MCTL:  rd_byte = mctl_q;
         TGT_LSTAT: rd_byte = lstat;
         TGT_MSTAT: rd_byte = mstat;
         TGT_SCR:   rd_byte = scr_q;
         TGT_GCTL:  rd_byte = gctl_q;
         default:   rd_byte = '0;
      endcase
   end

   assign bus_rdata        = DATA_W'(rd_byte);
   assign tx_load          = load_q;
   assign tx_byte          = thr_q;
   assign divisor          = {dlh_q, dll_q};
   assign word_len_m5      = lfmt_q.wlen;
   assign stop_ext         = lfmt_q.stop2;
   assign parity_en        = lfmt_q.par;
   assign parity_even      = lfmt_q.even;
   assign parity_stick     = lfmt_q.stick;
   assign break_force      = lfmt_q.brk;
   assign modem_ctl        = mctl_q;
   assign loop_en          = mctl_q[4];
   assign uart_clk_en      = gctl_q[0];
   assign tx_force_par_err = gctl_q[4];
   assign tx_force_frm_err = gctl_q[5];

   AST_DIV_ACCESS_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && bus_we && lfmt_q.div_acc |=> !tx_load); // R2
   AST_DIV_ACCESS_KEEPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      lfmt_q.div_acc |=> $stable(ien_q)); // R2
   AST_LOAD_HOLD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> !lstat[5] && !lstat[6]); // R3
   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load && !wr_thr |=> !tx_load); // R3
endmodule

// File: tb/test_uart_csr_file.sv
`timescale 1ns/1ps
module test_uart_csr_file;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rx_push = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
   logic [7:0]  rx_byte = '0;
   logic        tx_pop = 0, tx_shift_done = 0, cts_level = 0, cts_change = 0;
   logic        tx_load;
   logic [7:0]  tx_byte;
   logic [15:0] divisor;
   logic [1:0]  word_len_m5;
   logic        stop_ext, parity_en, parity_even, parity_stick, break_force;
   logic [7:0]  modem_ctl;
   logic        loop_en, uart_clk_en, tx_force_par_err, tx_force_frm_err, irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   uart_csr_file i_uart_csr_file (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .tx_pop(tx_pop),
      .tx_shift_done(tx_shift_done), .tx_load(tx_load), .tx_byte(tx_byte),
      .cts_level(cts_level), .cts_change(cts_change), .divisor(divisor),
      .word_len_m5(word_len_m5), .stop_ext(stop_ext), .parity_en(parity_en),
      .parity_even(parity_even), .parity_stick(parity_stick), .break_force(break_force),
      .modem_ctl(modem_ctl), .loop_en(loop_en), .uart_clk_en(uart_clk_en),
      .tx_force_par_err(tx_force_par_err), .tx_force_frm_err(tx_force_frm_err), .irq(irq)
   );

   task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic bwr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic brd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 0;
   endtask

   // 0 push, 1 parity, 2 framing, 3 break, 4 pop, 5 shift done, 6 cts change
   task automatic pulse(input int which, input logic [7:0] b);
      @(negedge clk);
      case (which)
         0: begin rx_push = 1; rx_byte = b; end
         1: rx_par_err = 1;
         2: rx_frm_err = 1;
         3: rx_brk = 1;
         4: tx_pop = 1;
         5: tx_shift_done = 1;
         default: cts_change = 1;
      endcase
      @(negedge clk);
      rx_push = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
      tx_pop = 0; tx_shift_done = 0; cts_change = 0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      check("R1", "irq", 16'(irq), 16'h0);
      check("R1", "tx_load", 16'(tx_load), 16'h0);
      check("R1", "divisor", divisor, 16'h0);
      brd(6'h14, d); check("R1", "line status", d, 16'h0060);
      brd(6'h0C, d); check("R1", "line format", d, 16'h0);
      brd(6'h04, d); check("R1", "enables", d, 16'h0);
      brd(6'h18, d); check("R1", "modem status", d, 16'h0);
   endtask

   task automatic t_divisor;
      logic [15:0] d;
      bwr(6'h0C, 16'h0080);
      bwr(6'h00, 16'h0034);
      check("R2", "no load under divisor access", 16'(tx_load), 16'h0);
      bwr(6'h04, 16'h0012);
      check("R2", "divisor out", divisor, 16'h1234);
      brd(6'h00, d); check("R2", "divisor low", d, 16'h0034);
      brd(6'h04, d); check("R2", "divisor high", d, 16'h0012);
      bwr(6'h0C, 16'h0000);
      brd(6'h04, d); check("R2", "enables untouched", d, 16'h0);
      brd(6'h14, d); check("R2", "holding still empty", d, 16'h0060);
   endtask

   task automatic t_thr_ien;
      logic [15:0] d;
      bwr(6'h00, 16'h00A5);
      check("R3", "tx_load pulse", 16'(tx_load), 16'h1);
      check("R3", "tx_byte", 16'(tx_byte), 16'h00A5);
      @(negedge clk);
      check("R3", "tx_load ends", 16'(tx_load), 16'h0);
      brd(6'h14, d); check("R3", "empties cleared", d, 16'h0000);
      bwr(6'h04, 16'hFFFF);
      brd(6'h04, d); check("R3", "enable width", d, 16'h000F);
      check("R3", "divisor kept", divisor, 16'h1234);
      bwr(6'h04, 16'h0000);
   endtask

   task automatic t_lfmt;
      bwr(6'h0C, 16'h007B);
      check("R4", "wlen", 16'(word_len_m5), 16'h3);
      check("R4", "stop/par/even/stick/brk", 16'({stop_ext, parity_en, parity_even, parity_stick, break_force}), 16'h0F);
      bwr(6'h0C, 16'h0004);
      check("R4", "wlen zero", 16'(word_len_m5), 16'h0);
      check("R4", "stop/par/even/stick/brk", 16'({stop_ext, parity_en, parity_even, parity_stick, break_force}), 16'h10);
      bwr(6'h0C, 16'h0000);
   endtask

   task automatic t_tx_status;
      logic [15:0] d;
      pulse(5, 8'h00);
      brd(6'h14, d); check("R8", "done while holding full ignored", d, 16'h0000);
      pulse(4, 8'h00);
      brd(6'h14, d); check("R8", "pop", d, 16'h0020);
      pulse(5, 8'h00);
      brd(6'h14, d); check("R8", "drained", d, 16'h00E0);
      bwr(6'h00, 16'h0042);
      brd(6'h14, d); check("R8", "new byte clears finished", d, 16'h0000);
      pulse(4, 8'h00);
      pulse(5, 8'h00);
      brd(6'h14, d); check("R8", "drained again", d, 16'h00E0);
   endtask

   task automatic t_rx;
      logic [15:0] d;
      pulse(0, 8'h5A);
      brd(6'h14, d); check("R5", "ready set", d, 16'h00E1);
      brd(6'h00, d); check("R5", "byte", d, 16'h005A);
      brd(6'h14, d); check("R5", "ready cleared", d, 16'h00E0);
   endtask

   task automatic t_overrun;
      logic [15:0] d;
      pulse(0, 8'h11);
      pulse(0, 8'h22);
      brd(6'h14, d); check("R6", "overrun", d, 16'h00E3);
      brd(6'h14, d); check("R7", "overrun cleared, ready kept", d, 16'h00E1);
      brd(6'h00, d); check("R6", "newest byte", d, 16'h0022);
      brd(6'h14, d); check("R5", "ready cleared", d, 16'h00E0);
   endtask

   task automatic t_sticky;
      logic [15:0] d;
      pulse(1, 8'h00);
      pulse(2, 8'h00);
      pulse(3, 8'h00);
      repeat (5) @(negedge clk);
      brd(6'h14, d); check("R7", "errors held", d, 16'h00FC);
      brd(6'h14, d); check("R7", "errors cleared", d, 16'h00E0);
   endtask

   task automatic t_mstat;
      logic [15:0] d;
      cts_level = 1;
      brd(6'h18, d); check("R9", "level", d, 16'h0010);
      pulse(6, 8'h00);
      brd(6'h18, d); check("R9", "delta set", d, 16'h0011);
      brd(6'h18, d); check("R9", "delta cleared", d, 16'h0010);
      cts_level = 0;
      brd(6'h18, d); check("R9", "level low", d, 16'h0000);
   endtask

   task automatic t_irq;
      logic [15:0] d;
      @(negedge clk);
      check("R10", "masked", 16'(irq), 16'h0);
      bwr(6'h04, 16'h0002); @(negedge clk);
      check("R10", "holding empty", 16'(irq), 16'h1);
      bwr(6'h04, 16'h0001); @(negedge clk);
      check("R10", "ready enabled, no data", 16'(irq), 16'h0);
      pulse(0, 8'h77); @(negedge clk);
      check("R10", "ready", 16'(irq), 16'h1);
      brd(6'h00, d); @(negedge clk);
      check("R10", "ready consumed", 16'(irq), 16'h0);
      bwr(6'h04, 16'h0004);
      pulse(2, 8'h00); @(negedge clk);
      check("R10", "line error", 16'(irq), 16'h1);
      brd(6'h14, d); @(negedge clk);
      check("R10", "line error read", 16'(irq), 16'h0);
      bwr(6'h04, 16'h0008);
      pulse(6, 8'h00); @(negedge clk);
      check("R10", "modem delta", 16'(irq), 16'h1);
      brd(6'h18, d); @(negedge clk);
      check("R10", "modem delta read", 16'(irq), 16'h0);
      bwr(6'h04, 16'h0000);
   endtask

   task automatic t_misc;
      logic [15:0] d;
      bwr(6'h10, 16'h0013);
      check("R11", "loop_en", 16'(loop_en), 16'h1);
      check("R11", "modem_ctl", 16'(modem_ctl), 16'h0013);
      brd(6'h10, d); check("R11", "modem readback", d, 16'h0013);
      bwr(6'h24, 16'h0031);
      check("R11", "clk/fpe/ffe", 16'({uart_clk_en, tx_force_par_err, tx_force_frm_err}), 16'h7);
      brd(6'h24, d); check("R11", "global readback", d, 16'h0031);
      bwr(6'h1C, 16'h00C3);
      brd(6'h1C, d); check("R11", "scratch", d, 16'h00C3);
   endtask

   task automatic t_ignored;
      logic [15:0] d;
      bwr(6'h14, 16'hFFFF);
      brd(6'h14, d); check("R12", "line status write ignored", d, 16'h00E0);
      bwr(6'h18, 16'hFFFF);
      brd(6'h18, d); check("R12", "modem status write ignored", d, 16'h0000);
      bwr(6'h08, 16'h00FF);
      brd(6'h08, d); check("R12", "slot 0x08", d, 16'h0000);
      bwr(6'h20, 16'h00FF);
      brd(6'h20, d); check("R12", "unmapped", d, 16'h0000);
      bwr(6'h1D, 16'h0055);
      brd(6'h1D, d); check("R12", "misaligned read", d, 16'h0000);
      brd(6'h1C, d); check("R12", "scratch after misaligned write", d, 16'h00C3);
      @(negedge clk);
      check("R12", "irq quiet", 16'(irq), 16'h0);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_divisor();
      t_thr_ien();
      t_lfmt();
      t_tx_status();
      t_rx();
      t_overrun();
      t_sticky();
      t_mstat();
      t_irq();
      t_misc();
      t_ignored();
      summary();
      $finish;
   end
endmodule